// File: doc/BRIEF.md
# Power-Fail Write-Protect Supervisor

This block sits between a host bus and a battery-backed byte-wide memory core. It tracks the health of the main supply through three digitised comparator flags, each sampled once per clock: supply above the upper deselect threshold, above the lower deselect threshold, and above the battery switchover level. From these flags it decides whether the core may be accessed.

When the supply is healthy and a recovery delay has run out, the host's active-low chip-enable, output-enable and write-enable pass straight to the core. When the supply sags, the block write-protects and deselects the core, asks for the data pins to go to high impedance, and ignores the host's controls. Below the switchover level it selects the battery. On the way back up, protection holds for a set number of clock cycles after the upper threshold is seen again. A write strobe that is already held low at release is not honoured until it has been seen high once.

The supervisor has five states: run, window (deselected), low (below the lower threshold), battery and recovery. The only way into battery is through window and then low. The only way into run is through a recovery period that completes without interruption.

Top module: `pfail_guard`

## Requirements
- R1: While reset is asserted and after its release, the core strobes are held high (inactive), `wprot` and `dq_hiz` are 1 and `bat_sel` is 0.
- R2: If the upper flag is sampled low while running, the core is protected from the second rising edge after the flag drops. Protected means all three core strobes high and `wprot`=1, `dq_hiz`=1. While protected, changes on the host strobes have no effect on any output.
- R3: While the lower flag is sampled low and the switchover flag high, the core stays protected and `bat_sel` stays 0.
- R4: `bat_sel` goes to 1 only after passing through the window and low states. When all flags fall at once from run, it rises on the fourth rising edge. It falls on the second rising edge after the switchover flag returns high.
- R5: After the upper flag is sampled high in the window state, protection lasts exactly `REC_CYC` cycles in recovery. Run starts on edge 2+`REC_CYC` counted from the flag's change.
- R6: If the upper flag drops during recovery, the block returns to window, and a later recovery needs the full `REC_CYC` cycles again.
- R7: While running, `core_ce_n`, `core_oe_n` and `core_we_n` equal the host strobes in the same cycle. `dq_hiz` is 0 only when chip-enable and output-enable are low and write-enable is high.
- R8: A write that is under way when the supply dips is cut off: `core_we_n` goes high in the first cycle the block leaves run, even though `host_we_n` stays low.
- R9: If `host_we_n` is low when protection is released, `core_we_n` stays high until `host_we_n` has been sampled high at one rising edge. After that, a low `host_we_n` passes through.
- R10: A one-sample low spike on the upper flag while running deselects the core and triggers a complete recovery period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sup_hi | input | 1 | 1 = supply above upper deselect threshold |
| sup_lo | input | 1 | 1 = supply above lower deselect threshold |
| sup_sw | input | 1 | 1 = supply above battery switchover level |
| host_ce_n | input | 1 | Host chip-enable, active low |
| host_oe_n | input | 1 | Host output-enable, active low |
| host_we_n | input | 1 | Host write-enable, active low |
| core_ce_n | output | 1 | Gated chip-enable to core |
| core_oe_n | output | 1 | Gated output-enable to core |
| core_we_n | output | 1 | Gated write-enable to core |
| wprot | output | 1 | 1 = core write-protected and deselected |
| dq_hiz | output | 1 | 1 = data pins must be high impedance |
| bat_sel | output | 1 | 1 = run core from battery |

## Verification
The gating path is tried with a table of host strobe combinations while running: idle, read, output-enable blocked, write, and write with output-enable low. This separates pass-through from the tristate decision. The supply path is tried with three patterns: a staged dip through window and low, a collapse of all flags at once, and a one-sample spike. Their timing shows whether the block deselects at once and whether the battery is reached only by stepping down. A dip during recovery, checked against the exact release edge, shows that the timer restarts rather than resumes. A strobe held low across release shows that the re-arm rule blocks the spurious write.

// File: rtl/pfg_pkg.sv
package pfg_pkg;

    typedef enum logic [2:0] {
        PF_RUN    = 3'd0,
        PF_WINDOW = 3'd1,
        PF_LOW    = 3'd2,
        PF_BATT   = 3'd3,
        PF_RECOV  = 3'd4
    } pf_state_e;

    typedef enum logic [1:0] {
        LVL_DEAD = 2'd0,
        LVL_LOW  = 2'd1,
        LVL_WIN  = 2'd2,
        LVL_GOOD = 2'd3
    } pf_lvl_e;

    // Lowest failing threshold decides the level; inconsistent flag sets
    // resolve toward the worse supply.
    function automatic pf_lvl_e classify(input logic hi, input logic lo, input logic sw);
        pf_lvl_e l;
        if (!sw)      l = LVL_DEAD;
        else if (!lo) l = LVL_LOW;
        else if (!hi) l = LVL_WIN;
        else          l = LVL_GOOD;
        return l;
    endfunction

endpackage

// File: rtl/pfg_sampler.sv
module pfg_sampler #(
    parameter int N_FLAGS = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_FLAGS-1:0] raw_i,
    output logic [N_FLAGS-1:0] smp_o
);
    typedef struct packed {
        logic [N_FLAGS-1:0] flags;
    } smp_t;

    smp_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        for (int i = 0; i < N_FLAGS; i++) begin
            s_d.flags[i] = raw_i[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign smp_o = s_q.flags;
endmodule

// File: rtl/pfg_rec_timer.sv
module pfg_rec_timer #(
    parameter int REC_CYC = 250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic done_o
);
    localparam int CW = $clog2(REC_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(REC_CYC - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (!run_i)              t_d.cnt = '0;
        else if (t_q.cnt != LAST) t_d.cnt = t_q.cnt + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign done_o = run_i && (t_q.cnt == LAST);

    // R5
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        t_q.cnt <= LAST);

    // R6
    cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !$past(run_i)) |-> (t_q.cnt == '0));
endmodule

// File: rtl/pfg_fsm.sv
module pfg_fsm
    import pfg_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  pf_lvl_e lvl_i,
    input  logic    rec_done_i,
    output logic    recov_o,
    output logic    prot_o,
    output logic    bat_o
);
    typedef struct packed {
        pf_state_e st;
    } fsm_t;

    fsm_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        unique case (f_q.st)
            PF_RUN: begin
                if (lvl_i != LVL_GOOD) f_d.st = PF_WINDOW;
            end
            PF_WINDOW: begin
                if (lvl_i == LVL_GOOD)     f_d.st = PF_RECOV;
                else if (lvl_i != LVL_WIN) f_d.st = PF_LOW;
            end
            PF_LOW: begin
                if (lvl_i == LVL_DEAD)     f_d.st = PF_BATT;
                else if (lvl_i != LVL_LOW) f_d.st = PF_WINDOW;
            end
            PF_BATT: begin
                if (lvl_i != LVL_DEAD) f_d.st = PF_LOW;
            end
            PF_RECOV: begin
                if (lvl_i != LVL_GOOD) f_d.st = PF_WINDOW;
                else if (rec_done_i)   f_d.st = PF_RUN;
            end
            default: f_d.st = PF_WINDOW;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q.st <= PF_WINDOW;
        else        f_q    <= f_d;
    end

    assign recov_o = (f_q.st == PF_RECOV);
    assign prot_o  = (f_q.st != PF_RUN);
    assign bat_o   = (f_q.st == PF_BATT);

    // R4
    batt_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.st == PF_BATT && $past(f_q.st) != PF_BATT) |-> ($past(f_q.st) == PF_LOW));

    // R5
    recov_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.st == PF_RECOV && $past(f_q.st) != PF_RECOV) |-> ($past(lvl_i) == LVL_GOOD));

    // R5
    run_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.st == PF_RUN && $past(f_q.st) != PF_RUN) |-> ($past(f_q.st) == PF_RECOV && $past(rec_done_i)));
endmodule

// File: rtl/pfg_strobe_gate.sv
module pfg_strobe_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic prot_i,
    input  logic host_ce_n,
    input  logic host_oe_n,
    input  logic host_we_n,
    output logic core_ce_n,
    output logic core_oe_n,
    output logic core_we_n,
    output logic dq_hiz
);
    typedef struct packed {
        logic armed;
    } gate_t;

    gate_t g_d, g_q;

    // Arm is set whenever the strobe is seen high; while protected a low
    // strobe disarms, so a strobe held low across release stays blocked.
    always_comb begin
        g_d = g_q;
        if (host_we_n)   g_d.armed = 1'b1;
        else if (prot_i) g_d.armed = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    assign core_ce_n = prot_i | host_ce_n;
    assign core_oe_n = prot_i | host_oe_n;
    assign core_we_n = prot_i | ~g_q.armed | host_we_n;
    assign dq_hiz    = prot_i | host_ce_n | host_oe_n | ~host_we_n;

    // R9
    we_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !core_we_n |-> ($past(host_we_n) || !$past(core_we_n)));
endmodule

// File: rtl/pfail_guard.sv
module pfail_guard #(
    parameter int REC_CYC = 250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sup_hi,
    input  logic sup_lo,
    input  logic sup_sw,
    input  logic host_ce_n,
    input  logic host_oe_n,
    input  logic host_we_n,
    output logic core_ce_n,
    output logic core_oe_n,
    output logic core_we_n,
    output logic wprot,
    output logic dq_hiz,
    output logic bat_sel
);
    import pfg_pkg::*;

    localparam int N_FLAGS = 3;

    logic [N_FLAGS-1:0] smp;
    pf_lvl_e            lvl;
    logic               recov, done, prot;

    pfg_sampler #(.N_FLAGS(N_FLAGS)) u_smp (
        .clk   (clk),
        .rst_n (rst_n),
        .raw_i ({sup_hi, sup_lo, sup_sw}),
        .smp_o (smp)
    );

    assign lvl = classify(smp[2], smp[1], smp[0]);

    pfg_rec_timer #(.REC_CYC(REC_CYC)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (recov),
        .done_o (done)
    );

    pfg_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .lvl_i      (lvl),
        .rec_done_i (done),
        .recov_o    (recov),
        .prot_o     (prot),
        .bat_o      (bat_sel)
    );

    pfg_strobe_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .prot_i    (prot),
        .host_ce_n (host_ce_n),
        .host_oe_n (host_oe_n),
        .host_we_n (host_we_n),
        .core_ce_n (core_ce_n),
        .core_oe_n (core_oe_n),
        .core_we_n (core_we_n),
        .dq_hiz    (dq_hiz)
    );

    assign wprot = prot;

    // R2
    prot_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wprot |-> (core_ce_n && core_oe_n && core_we_n && dq_hiz));

    // R8
    dip_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(sup_hi) && !$past(sup_hi, 2) |-> wprot);
endmodule

// File: tb/pfail_guard_tb.sv
module pfail_guard_tb;
    localparam int REC = 16;

    logic clk = 1'b0;
    logic rst_n;
    logic sup_hi, sup_lo, sup_sw;
    logic host_ce_n, host_oe_n, host_we_n;
    logic core_ce_n, core_oe_n, core_we_n, wprot, dq_hiz, bat_sel;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    pfail_guard #(.REC_CYC(REC)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .sup_hi(sup_hi), .sup_lo(sup_lo), .sup_sw(sup_sw),
        .host_ce_n(host_ce_n), .host_oe_n(host_oe_n), .host_we_n(host_we_n),
        .core_ce_n(core_ce_n), .core_oe_n(core_oe_n), .core_we_n(core_we_n),
        .wprot(wprot), .dq_hiz(dq_hiz), .bat_sel(bat_sel)
    );

    // packed outputs: {ce, oe, we, hiz, wprot, bat}
    function automatic logic [5:0] outs();
        return {core_ce_n, core_oe_n, core_we_n, dq_hiz, wprot, bat_sel};
    endfunction

    task automatic chk(input string req, input logic [5:0] act, input logic [5:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic chk1(input string req, input logic act, input logic exp);
        chk(req, {5'b0, act}, {5'b0, exp});
    endtask

    // advance n rising edges, return at the following falling edge
    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    localparam logic [5:0] PROT = 6'b111110;
    localparam logic [5:0] BATT = 6'b111111;

    // {ce, oe, we} -> {core ce, oe, we, hiz}
    localparam logic [6:0] VEC [7] = '{
        7'b111_1111,
        7'b001_0010,
        7'b011_0111,
        7'b010_0101,
        7'b000_0001,
        7'b100_1001,
        7'b101_1011
    };

    initial begin
        rst_n = 1'b0;
        {sup_hi, sup_lo, sup_sw} = 3'b000;
        {host_ce_n, host_oe_n, host_we_n} = 3'b111;
        step(3);
        chk("R1 in reset", outs(), PROT);
        rst_n = 1'b1;
        step(1);
        chk("R1 after release", outs(), PROT);

        // dead supply settles in battery
        step(4);
        chk("R4 dead supply", outs(), BATT);

        // power up from battery
        {sup_hi, sup_lo, sup_sw} = 3'b111;
        step(1);
        chk1("R4 still battery", bat_sel, 1'b1);
        step(1);
        chk("R4 released", outs(), PROT);
        step(REC + 1);
        chk1("R5 before expiry", wprot, 1'b1);
        step(1);
        chk1("R5 at expiry", wprot, 1'b0);

        // pass-through table
        foreach (VEC[i]) begin
            {host_ce_n, host_oe_n, host_we_n} = VEC[i][6:4];
            #2;
            chk($sformatf("R7 vec%0d", i), {core_ce_n, core_oe_n, core_we_n, dq_hiz, 2'b00},
                {VEC[i][3:0], 2'b00});
            @(negedge clk);
        end

        // write in progress, then supply dips into window
        {host_ce_n, host_oe_n, host_we_n} = 3'b010;
        step(1);
        sup_hi = 1'b0;
        step(1);
        chk1("R8 still running", core_we_n, 1'b0);
        step(1);
        chk("R8 write cut", outs(), PROT);
        {host_ce_n, host_oe_n, host_we_n} = 3'b001;
        #2;
        chk("R2 host ignored", outs(), PROT);
        {host_ce_n, host_oe_n, host_we_n} = 3'b000;

        // below lower threshold
        sup_lo = 1'b0;
        step(2);
        chk("R3 low", outs(), PROT);
        step(4);
        chk("R3 low held", outs(), PROT);

        // recover with we held low, dip during recovery
        {sup_hi, sup_lo} = 2'b11;
        step(3);
        chk("R5 in recovery", outs(), PROT);
        step(5);
        sup_hi = 1'b0;
        step(1);
        sup_hi = 1'b1;
        step(REC + 1);
        chk1("R6 restarted", wprot, 1'b1);
        step(1);
        chk1("R6 released", wprot, 1'b0);
        chk1("R9 ce passes", core_ce_n, 1'b0);
        chk1("R9 held low blocked", core_we_n, 1'b1);
        step(3);
        chk1("R9 still blocked", core_we_n, 1'b1);
        host_we_n = 1'b1;
        step(1);
        host_we_n = 1'b0;
        #2;
        chk1("R9 rearmed", core_we_n, 1'b0);
        @(negedge clk);
        host_we_n = 1'b1;

        // single-sample spike
        sup_hi = 1'b0;
        step(1);
        sup_hi = 1'b1;
        step(1);
        chk1("R10 deselect", wprot, 1'b1);
        step(REC);
        chk1("R10 full recovery", wprot, 1'b1);
        step(1);
        chk1("R10 released", wprot, 1'b0);

        // collapse of all flags at once
        {sup_hi, sup_lo, sup_sw} = 3'b000;
        step(3);
        chk1("R4 not yet battery", bat_sel, 1'b0);
        step(1);
        chk("R4 battery", {core_ce_n, core_oe_n, 1'b1, dq_hiz, wprot, bat_sel}, BATT);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule